// File: doc/BRIEF.md
# Seeded Shift-Register Random Byte Source

This block produces a fresh pseudorandom byte on every clock. Inside it is a 32-bit Fibonacci-style shift register. On each step every bit moves one place toward the most significant end. Bit 0 takes the exclusive-OR of state positions 31, 19, 10 and 2. A controller samples the low byte through an ordinary input port whenever it needs a random value, for example to pick display digits.

Reset places a fixed boot seed of 0x94AC2DE7 in the register. While the load control is high, software or surrounding logic can overwrite the whole state with any 32-bit value.

The output is a free-running sample, not a stream. It is valid in every cycle, it has no ready input, and it cannot be back-pressured. A reader that skips cycles simply misses those values. The register never waits for a reader.

Top module: `lfsr_rand_src`

## Requirements
- R1: While `rst_n` is low, the state is forced to 0x94AC2DE7, so `rnd_o` reads 0xE7.
- R2: A rising clock edge with `load_i` high copies all 32 bits of `seed_i` into the state. `rnd_o` shows `seed_i[7:0]` from that edge onward.
- R3: Load takes priority over stepping. While `load_i` stays high, the state follows `seed_i` and does not advance.
- R4: On every rising edge with `load_i` low, the new state is `{old[30:0], old[31]^old[19]^old[10]^old[2]}`.
- R5: `rnd_o` is state bits 7..0. It changes only at a rising clock edge, or when reset is asserted.
- R6: Stepping from a nonzero state never yields the all-zero state.
- R7: A zero seed is a lock-up point. After loading 0, stepping keeps the state, and so `rnd_o`, at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the boot seed |
| load_i | input | 1 | Parallel load enable; has priority over stepping |
| seed_i | input | 32 | Value copied into the state when loading |
| rnd_o | output | 8 | Low byte of the current state |

## Verification
The bench follows the register with its own model over hundreds of steps, so a wrong tap, or a shift in the wrong direction, breaks the byte sequence within a few cycles. Bit 0 of `rnd_o` carries every new feedback bit, which lets the bench rebuild the full 32-bit state. A design that dropped into the all-zero state, or diverged in the upper bits, would show a mismatch there. A held load that still stepped would show changing bytes while the seed stays constant. A reset value other than the boot seed would show a low byte other than 0xE7. A loaded zero that escaped its lock-up would show nonzero bytes.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned STATE_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam logic [STATE_W-1:0] BOOT_SEED = 32'h94AC2DE7;
  localparam logic [STATE_W-1:0] TAP_MASK =
    (32'd1 << 31) | (32'd1 << 19) | (32'd1 << 10) | (32'd1 << 2);
endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic [W-1:0] state_i,
  output logic         fb_o
);
  logic [W-1:0] picked;

  for (genvar b = 0; b < W; b++) begin : g_tap
    if (MASK[b]) begin : g_on
      assign picked[b] = state_i[b];
    end else begin : g_off
      assign picked[b] = 1'b0;
    end
  end

  assign fb_o = ^picked;
endmodule

// File: rtl/lfsr_step.sv
module lfsr_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] state_i,
  input  logic         fb_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] next_o
);
  always_comb begin
    if (load_i) next_o = seed_i;
    else        next_o = {state_i[W-2:0], fb_i};
  end
endmodule

// File: rtl/lfsr_rand_src.sv
module lfsr_rand_src
  import lfsr_pkg::*;
#(
  parameter int unsigned W = STATE_W,
  parameter int unsigned OUT_W = BYTE_W,
  parameter logic [W-1:0] SEED0 = BOOT_SEED,
  parameter logic [W-1:0] TAPS = TAP_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     seed_i,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  lfsr_feedback #(.W(W), .MASK(TAPS)) u_fb (
    .state_i(state_q),
    .fb_o   (fb)
  );

  lfsr_step #(.W(W)) u_step (
    .state_i(state_q),
    .fb_i   (fb),
    .load_i (load_i),
    .seed_i (seed_i),
    .next_o (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED0;
    else        state_q <= state_d;
  end

  assign rnd_o = state_q[OUT_W-1:0];

  assert_reset_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> state_q == SEED0);

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_i)) |-> state_q == $past(seed_i));

  assert_shift_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_i)) |-> state_q[W-1:1] == $past(state_q[W-2:0]));

  assert_feedback_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_i)) |-> state_q[0] == ^($past(state_q) & TAPS));

  assert_no_lockup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_i) && $past(state_q) != '0) |-> state_q != '0);

  assert_zero_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_i) && $past(state_q) == '0) |-> state_q == '0);
endmodule

// File: tb/lfsr_rand_src_bench.sv
`timescale 1ns/1ps
module lfsr_rand_src_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] seed_i = '0;
  logic [7:0]  rnd_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = 32'h94AC2DE7;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lfsr_rand_src u_lfsr_rand_src (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i), .rnd_o(rnd_o)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[19] ^ s[10] ^ s[2]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (load_i) model = seed_i;
    else        model = nxt(model);
    @(negedge clk);
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0;
    load_i = 1'b1;
    seed_i = 32'h12345678;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset seed", {24'd0, rnd_o}, 32'hE7);
    load_i = 1'b0;
    rst_n = 1'b1;
    model = 32'h94AC2DE7;
    tick();
    chk("R4 first step after reset", {24'd0, rnd_o}, {24'd0, model[7:0]});
  endtask

  task automatic t_load_R2();
    seed_i = 32'hA5C3_0F3C;
    load_i = 1'b1;
    #1;
    chk("R5 no change before edge", {24'd0, rnd_o}, {24'd0, model[7:0]});
    tick();
    chk("R2 loaded byte", {24'd0, rnd_o}, 32'h3C);
    load_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      tick();
      chk("R4 step after load", {24'd0, rnd_o}, {24'd0, model[7:0]});
    end
  endtask

  task automatic t_hold_R3();
    seed_i = 32'h0000_01D2;
    load_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R3 held load", {24'd0, rnd_o}, 32'hD2);
    end
    seed_i = 32'h0000_0077;
    tick();
    chk("R3 follows new seed", {24'd0, rnd_o}, 32'h77);
    load_i = 1'b0;
  endtask

  task automatic t_run_R6();
    logic [31:0] hist;
    hist = '0;
    seed_i = 32'h0000_0001;
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    for (int k = 0; k < 400; k++) begin
      tick();
      hist = {hist[30:0], rnd_o[0]};
      chk("R4 free run byte", {24'd0, rnd_o}, {24'd0, model[7:0]});
      if (k >= 31) begin
        chk("R6 rebuilt state", hist, model);
        checks++;
        if (hist == 32'd0) begin
          failures++;
          $display("FAIL R6 state zero actual=%h expected=nonzero", hist);
        end
      end
    end
  endtask

  task automatic t_zero_R7();
    seed_i = 32'd0;
    load_i = 1'b1;
    tick();
    load_i = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick();
      chk("R7 zero lock-up", {24'd0, rnd_o}, 32'd0);
    end
  endtask

  task automatic t_reset_again_R1();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {24'd0, rnd_o}, 32'hE7);
    @(negedge clk);
    rst_n = 1'b1;
    model = 32'h94AC2DE7;
    for (int k = 0; k < 10; k++) begin
      tick();
      chk("R4 boot sequence", {24'd0, rnd_o}, {24'd0, model[7:0]});
    end
  endtask

  initial begin
    t_reset_R1();
    t_load_R2();
    t_hold_R3();
    t_run_R6();
    t_zero_R7();
    t_reset_again_R1();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule